// File: doc/BRIEF.md
# Alarm-Driven Power-Off Controller

This block watches the running calendar time and compares it against six programmable BCD compare fields (seconds, minutes, hours, day, month, year). When the seconds value updates and every field matches, it latches an event flag and, if enabled, raises an interrupt. The calendar counter lives elsewhere; this block only receives the current time as a packed BCD vector together with a one-cycle pulse that marks each seconds update.

The block can also switch off the system supply. Software sets an arm bit in the power-control register. After that, a match drives the active-high power-enable output to its off level (0). The output then stays off until the block is reset. Without the arm bit, a match only sets the flag and the interrupt, and the pin does not move.

Software programs the block over a simple word-addressed write bus with byte strobes and a combinational read port. The interrupt-enable register takes a write only as a full word (all four strobes). A write on fewer lanes to that register has no effect.

Top module: `pwroff_alarm_top`

## Requirements
- R1: After reset, pwr_en is 1, irq is 0, and every register reads 0. This covers the six compare fields, interrupt enable, status flag and arm bit.
- R2: The compare fields sit at byte offsets 0x00 (seconds), 0x04 (minutes), 0x08 (hours), 0x0C (day), 0x10 (month) and 0x14 (year). Each holds 8 bits in data bits [7:0]. A write with strobe bit 0 set stores the value, and a read at the same offset returns it.
- R3: When sec_tick is high at a clock edge and all six fields of now_bcd equal the compare fields, the status flag (offset 0x1C, bit 0) reads 1 after the second following edge and not earlier. now_bcd is packed {year, month, day, hours, minutes, seconds}, with seconds in bits [7:0].
- R4: There is no flag without a sec_tick, and no flag when any single field differs.
- R5: Writing 1 to status bit 0 clears the flag. If a new match sets the flag at the same edge as the clear, the set wins.
- R6: irq is 1 exactly while the flag is 1 and the interrupt enable (offset 0x18, bit 0) is 1.
- R7: The interrupt-enable register changes only on a write with all four strobes set. A write with fewer strobes leaves it unchanged.
- R8: With the arm bit (offset 0x20, bit 0) set, a match drives pwr_en to 0 at the same edge that sets the flag.
- R9: Once pwr_en is 0, it stays 0 through later writes and ticks until reset. Clearing the arm bit or the flag does not restore it. Reset returns it to 1.
- R10: With the arm bit clear, a match sets the flag but leaves pwr_en at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick | input | 1 | One-cycle pulse on each seconds update of the calendar |
| now_bcd | input | 48 | Current BCD time {year, month, day, hours, minutes, seconds} |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane enables of the write |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwr_en | output | 1 | Power enable, 1 = supply on, 0 = off |
| irq | output | 1 | Interrupt: flag and enable both set |

## Verification
A tick sampled at edge E1 registers the match at E1. The flag and the power pin then change at E2, and irq follows the flag with no further delay. Register writes take effect at the edge that samples them, and reads are combinational. The bench drives inputs on falling edges and samples one step after a rising edge or at a falling edge. For each match it checks the state both after E1 (still unchanged) and after E2 (changed). This catches a design that is one stage early or one stage late.

// File: rtl/pwroff_pkg.sv
package pwroff_pkg;
  localparam int FIELD_W = 8;
  localparam int NFIELDS = 6;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;
  localparam int STRB_W  = DATA_W / 8;

  localparam logic [ADDR_W-1:0] OFS_IE   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_ARM  = 6'h20;

  typedef enum logic {PWR_ON = 1'b0, PWR_OFF = 1'b1} pwr_state_e;
endpackage

// File: rtl/pwroff_regs.sv
module pwroff_regs
  import pwroff_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NF = NFIELDS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [STRB_W-1:0]   wstrb,
  input  logic                match_i,
  output logic [DATA_W-1:0]   rdata,
  output logic [NF*FW-1:0]    cmp_o,
  output logic                ie_o,
  output logic                arm_o,
  output logic                flag_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:FW];

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    logic [FW-1:0] fld_d, fld_q;
    always_comb begin
      fld_d = fld_q;
      if (wr_en && wstrb[0] && addr == ADDR_W'(g * 4))
        fld_d = wdata[FW-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fld_q <= '0;
      else        fld_q <= fld_d;
    end
    assign cmp_o[g*FW +: FW] = fld_q;
  end

  logic ie_d, ie_q, arm_d, arm_q, flag_d, flag_q;
  logic ie_wr, arm_wr, clr_wr;

  assign ie_wr  = wr_en && (addr == OFS_IE) && (&wstrb);
  assign arm_wr = wr_en && (addr == OFS_ARM) && wstrb[0];
  assign clr_wr = wr_en && (addr == OFS_STAT) && wstrb[0] && wdata[0];

  always_comb begin
    ie_d   = ie_wr  ? wdata[0] : ie_q;
    arm_d  = arm_wr ? wdata[0] : arm_q;
    flag_d = flag_q;
    if (clr_wr)  flag_d = 1'b0;
    if (match_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      arm_q  <= arm_d;
      flag_q <= flag_d;
    end
  end

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  always_comb begin
    rdata = '0;
    if (int'(idx) < NF && addr[1:0] == 2'b00)
      rdata[FW-1:0] = cmp_o[int'(idx)*FW +: FW];
    else if (addr == OFS_IE)
      rdata[0] = ie_q;
    else if (addr == OFS_STAT)
      rdata[0] = flag_q;
    else if (addr == OFS_ARM)
      rdata[0] = arm_q;
  end

  assign ie_o   = ie_q;
  assign arm_o  = arm_q;
  assign flag_o = flag_q;

  // R3 / R5: a registered match always leaves the flag set, even against a clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_i |=> flag_q);

  // R3: the flag only rises after a match
  p_flag_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(match_i));

  // R7: a partial-lane write leaves the enable untouched
  p_ie_partial_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_IE && !(&wstrb)) |=> $stable(ie_q));
endmodule

// File: rtl/pwroff_match.sv
module pwroff_match
  import pwroff_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int NF = NFIELDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [NF*FW-1:0] now_i,
  input  logic [NF*FW-1:0] cmp_i,
  output logic             match_o
);
  logic [NF-1:0] eq;

  for (genvar g = 0; g < NF; g++) begin : g_eq
    assign eq[g] = (now_i[g*FW +: FW] == cmp_i[g*FW +: FW]);
  end

  logic match_d, match_q;
  assign match_d = tick_i && (&eq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  assign match_o = match_q;

  // R4: a match pulse only follows a seconds tick
  p_match_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> $past(tick_i));
endmodule

// File: rtl/pwroff_fsm.sv
module pwroff_fsm
  import pwroff_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic arm_i,
  output logic pwr_en_o
);
  pwr_state_e state_d, state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWR_ON:  if (match_i && arm_i) state_d = PWR_OFF;
      PWR_OFF: state_d = PWR_OFF;
      default: state_d = PWR_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PWR_ON;
    else        state_q <= state_d;
  end

  assign pwr_en_o = (state_q == PWR_ON);

  // R9: the off level is held
  p_off_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en_o |=> !pwr_en_o);

  // R8: switching off needs an armed match
  p_off_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en_o) |-> $past(match_i && arm_i));

  // R10: an unarmed match leaves the pin on
  p_unarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && !arm_i && pwr_en_o) |=> pwr_en_o);
endmodule

// File: rtl/pwroff_alarm_top.sv
module pwroff_alarm_top
  import pwroff_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sec_tick,
  input  logic [NFIELDS*FIELD_W-1:0] now_bcd,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic [STRB_W-1:0]         bus_wstrb,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      pwr_en,
  output logic                      irq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NFIELDS*FIELD_W-1:0] cmp;
  logic match, ie, arm, flag;

  pwroff_regs #(.FW(FIELD_W), .NF(NFIELDS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .wstrb   (bus_wstrb),
    .match_i (match),
    .rdata   (bus_rdata),
    .cmp_o   (cmp),
    .ie_o    (ie),
    .arm_o   (arm),
    .flag_o  (flag)
  );

  pwroff_match #(.FW(FIELD_W), .NF(NFIELDS)) u_match (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick_i  (sec_tick),
    .now_i   (now_bcd),
    .cmp_i   (cmp),
    .match_o (match)
  );

  pwroff_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .match_i  (match),
    .arm_i    (arm),
    .pwr_en_o (pwr_en)
  );

  assign irq = flag & ie;
endmodule

// File: tb/pwroff_alarm_top_tb.sv
module pwroff_alarm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sec_tick;
  logic [47:0] now_bcd;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_wstrb;
  logic [31:0] bus_rdata;
  logic        pwr_en;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  pwroff_alarm_top dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .now_bcd(now_bcd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata), .pwr_en(pwr_en), .irq(irq)
  );

  localparam logic [47:0] T_ALARM = {8'h37, 8'h12, 8'h28, 8'h23, 8'h59, 8'h58};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sec_tick = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; bus_wstrb = '0; now_bcd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic tick_once();
    @(negedge clk); sec_tick = 1'b1;
    @(posedge clk); #1; sec_tick = 1'b0;
  endtask

  task automatic load_alarm(input logic [47:0] t);
    for (int i = 0; i < 6; i++) wr(6'(i * 4), {24'h0, t[i*8 +: 8]}, 4'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 pwr_en", {31'b0, pwr_en}, 32'd1);
    check("R1 irq", {31'b0, irq}, 32'd0);
    for (int i = 0; i < 9; i++) begin
      rd(6'(i * 4), v);
      check("R1 register", v, 32'd0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] v;
    load_alarm(T_ALARM);
    for (int i = 0; i < 6; i++) begin
      rd(6'(i * 4), v);
      check("R2 field readback", v, {24'h0, T_ALARM[i*8 +: 8]});
    end
  endtask

  task automatic t_nomatch();
    logic [31:0] v;
    now_bcd = T_ALARM;
    repeat (4) @(posedge clk);
    rd(6'h1C, v);
    check("R4 no tick no flag", v, 32'd0);
    for (int i = 0; i < 6; i++) begin
      now_bcd = T_ALARM;
      now_bcd[i*8 +: 8] = T_ALARM[i*8 +: 8] ^ 8'h01;
      tick_once();
      repeat (2) @(posedge clk);
      rd(6'h1C, v);
      check("R4 one field differs", v, 32'd0);
    end
  endtask

  task automatic t_match_unarmed();
    logic [31:0] v;
    now_bcd = T_ALARM;
    tick_once();
    rd(6'h1C, v);
    check("R3 flag not yet after first edge", v, 32'd0);
    @(posedge clk); #1;
    rd(6'h1C, v);
    check("R3 flag after second edge", v, 32'd1);
    check("R10 pin stays on unarmed", {31'b0, pwr_en}, 32'd1);
    check("R6 irq off with enable clear", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_irq_enable();
    logic [31:0] v;
    wr(6'h18, 32'd1, 4'h1);
    rd(6'h18, v);
    check("R7 partial write ignored", v, 32'd0);
    check("R7 irq stays low", {31'b0, irq}, 32'd0);
    wr(6'h18, 32'd1, 4'h7);
    rd(6'h18, v);
    check("R7 three lanes ignored", v, 32'd0);
    wr(6'h18, 32'd1, 4'hF);
    rd(6'h18, v);
    check("R7 full word write", v, 32'd1);
    check("R6 irq with flag and enable", {31'b0, irq}, 32'd1);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(6'h1C, 32'd0, 4'hF);
    rd(6'h1C, v);
    check("R5 writing 0 keeps flag", v, 32'd1);
    wr(6'h1C, 32'd1, 4'hF);
    rd(6'h1C, v);
    check("R5 clear by writing 1", v, 32'd0);
    check("R6 irq drops with flag", {31'b0, irq}, 32'd0);
    now_bcd = T_ALARM;
    tick_once();
    wr(6'h1C, 32'd1, 4'hF);
    rd(6'h1C, v);
    check("R5 set wins over clear", v, 32'd1);
    wr(6'h1C, 32'd1, 4'hF);
  endtask

  task automatic t_armed();
    logic [31:0] v;
    wr(6'h20, 32'd1, 4'h1);
    rd(6'h20, v);
    check("R8 arm readback", v, 32'd1);
    now_bcd = T_ALARM;
    tick_once();
    check("R8 pin on after first edge", {31'b0, pwr_en}, 32'd1);
    @(posedge clk); #1;
    check("R8 pin off after second edge", {31'b0, pwr_en}, 32'd0);
    check("R6 irq with armed match", {31'b0, irq}, 32'd1);
  endtask

  task automatic t_sticky();
    wr(6'h20, 32'd0, 4'hF);
    wr(6'h1C, 32'd1, 4'hF);
    now_bcd = T_ALARM ^ 48'h1;
    tick_once();
    repeat (3) @(posedge clk); #1;
    check("R9 off held after disarm and clear", {31'b0, pwr_en}, 32'd0);
    do_reset();
    check("R9 reset restores pin", {31'b0, pwr_en}, 32'd1);
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_regs();
    t_nomatch();
    t_match_unarmed();
    t_irq_enable();
    t_w1c();
    t_armed();
    t_sticky();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule